// File: doc/BRIEF.md
# Non-Volatile Store Cycle Sequencer

This block controls the save of a converter's live setting into a stored-value register that stands in for non-volatile cells. The serial front end reports each rising edge of the serial clock as a one-cycle strobe in the system clock domain. It raises a frame-complete strobe on the edge that captures the last data bit. A save is requested by holding the program input high at the next serial clock edge after that frame. When the request is accepted, the ready line falls and the busy flag rises. The serial front end uses the busy flag to ignore incoming data and keep its output quiet.

The erase/write duration is a parameter, counted in serial clock rising edges. The timer only advances while the serial clock runs. At the last edge of the duration, the code captured from the requesting frame is written into the stored-value register on a one-cycle strobe, and the ready line returns high on that same edge. A supply-low flag that is active at the sampling edge blocks the cycle, so the ready line never falls. The write strobe is a valid-only stream with no back-pressure: the storage always accepts, and each strobe carries the data on the stored-value bus in that cycle.

Top module: `nv_store_seq`

## Requirements
- R1: After reset, ready_busy is 1, busy is 0, store_we is 0 and stored_code equals the parameter RESET_CODE.
- R2: A serial edge with frame_done set captures live_code and arms the block. If prog is 1 at the next serial edge and supply_low is 0, busy reads 1 and ready_busy reads 0 from the cycle after that edge.
- R3: If prog is 0 at the first serial edge after the frame, no cycle starts and the arming is dropped. A prog of 1 at any later edge, with no new frame, starts nothing.
- R4: Busy lasts exactly BUSY_EDGES serial rising edges after the starting edge. System cycles without a serial edge do not advance the timer.
- R5: On the final busy edge, store_we pulses for exactly one cycle, stored_code takes the captured code, and busy and ready_busy return to 0 and 1 in that same cycle.
- R6: If supply_low is 1 at the sampling edge, ready_busy stays 1, busy stays 0, store_we does not pulse and stored_code is unchanged. The arming is dropped.
- R7: While busy, frame_done and prog have no effect. The captured code is not replaced, the timer is not restarted, and the block is not left armed afterwards.
- R8: The stored value is the live_code seen at the frame's frame_done edge. Changes to live_code after that edge do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| frame_done | input | 1 | Set with sclk_rise on the edge that captured the last data bit |
| prog | input | 1 | Store request level |
| live_code | input | W | Current control-register code |
| supply_low | input | 1 | Supply too low for programming |
| ready_busy | output | 1 | 1 = ready, 0 = erase/write in progress |
| busy | output | 1 | Tells the serial front end to ignore data in and keep data out quiet |
| stored_code | output | W | Stored-value register |
| store_we | output | 1 | One-cycle write strobe for stored_code |

## Verification
Two events can land in the same cycle. One is a new frame, with a store request, arriving on a serial edge during the busy period. The other is the commit and the ready return on the final timer edge. The bench provokes this by sending a frame with a different code and prog high in mid-cycle, and by placing a frame-and-request at the exact final edge in random runs. It then judges that the committed code is the original one, that the end edge is unchanged, and that the block is not left armed.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BUSY  = 2'd2
  } nvs_state_e;
endpackage

// File: rtl/nvs_snapshot.sv
module nvs_snapshot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
  parameter int N = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic done,
  output logic running
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LOAD = CW'(N);

  logic [CW-1:0] cnt;

  assign running = (cnt != '0);
  assign done    = tick && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (start)            cnt <= LOAD;
    else if (tick && running)  cnt <= cnt - CW'(1);
  end

  // R4: count only moves on a serial edge
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !start) |=> $stable(cnt));
  // R7: no restart while a cycle runs
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !running);
endmodule

// File: rtl/nvs_commit.sv
module nvs_commit #(
  parameter int W = 8,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         we_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= RESET_CODE;
      we_q <= 1'b0;
    end else begin
      we_q <= we;
      if (we) q <= d;
    end
  end

  // R5: one-cycle strobe
  p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);
  // R6: stored value moves only with its strobe
  p_code_only_on_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q) |-> we_q);
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int W = 8,
  parameter int BUSY_EDGES = 4500,
  parameter logic [W-1:0] RESET_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_rise,
  input  logic         frame_done,
  input  logic         prog,
  input  logic [W-1:0] live_code,
  input  logic         supply_low,
  output logic         ready_busy,
  output logic         busy,
  output logic [W-1:0] stored_code,
  output logic         store_we
);
  import nvs_pkg::*;

  nvs_state_e state, state_nx;
  logic       go, snap_load, t_done, t_run;
  logic [W-1:0] snap;

  assign go = (state == ST_ARMED) && sclk_rise && prog && !supply_low;
  assign snap_load = sclk_rise && frame_done &&
                     ((state == ST_IDLE) || ((state == ST_ARMED) && !go));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (snap_load) state_nx = ST_ARMED;
      ST_ARMED: if (go) state_nx = ST_BUSY;
                else if (snap_load) state_nx = ST_ARMED;
                else if (sclk_rise) state_nx = ST_IDLE;
      ST_BUSY:  if (t_done) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  nvs_snapshot #(.W(W)) u_snap (
    .clk(clk), .rst_n(rst_n), .load(snap_load), .d(live_code), .q(snap)
  );

  nvs_timer #(.N(BUSY_EDGES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(go), .tick(sclk_rise && (state == ST_BUSY)),
    .done(t_done), .running(t_run)
  );

  nvs_commit #(.W(W), .RESET_CODE(RESET_CODE)) u_commit (
    .clk(clk), .rst_n(rst_n), .we(t_done), .d(snap), .q(stored_code), .we_q(store_we)
  );

  assign busy       = (state == ST_BUSY);
  assign ready_busy = !busy;

  // R2: accepted request raises busy on the next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy && t_run);
  // R5: strobe coincides with the end of busy
  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    store_we |-> (!busy && $past(busy)));
  // R6: low supply at an idle/armed edge never starts a cycle
  p_low_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && supply_low) |=> !busy);
  // R7: captured code is frozen while busy
  p_snap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(snap));
  // R4: busy and the timer agree
  p_timer_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> t_run);
endmodule

// File: tb/nv_store_seq_test.sv
module nv_store_seq_test;
  localparam int W = 8;
  localparam int NB = 6;
  localparam logic [W-1:0] RC = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic sclk_rise = 0, frame_done = 0, prog = 0, supply_low = 0;
  logic [W-1:0] live_code = '0;
  logic ready_busy, busy, store_we;
  logic [W-1:0] stored_code;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [W-1:0] exp_st;

  nv_store_seq #(.W(W), .BUSY_EDGES(NB), .RESET_CODE(RC)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .frame_done(frame_done),
    .prog(prog), .live_code(live_code), .supply_low(supply_low),
    .ready_busy(ready_busy), .busy(busy), .stored_code(stored_code), .store_we(store_we)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one system cycle with given inputs; returns at the following negedge
  task automatic tick(input bit sr, input bit fd, input bit pr, input bit lo);
    sclk_rise = sr; frame_done = fd; prog = pr; supply_low = lo;
    @(negedge clk);
    sclk_rise = 0; frame_done = 0; prog = 0; supply_low = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0);
  endtask

  task automatic send_frame(input logic [W-1:0] c);
    live_code = c;
    tick(1, 1, 0, 0);
    live_code = ~c;   // R8: later changes must not matter
  endtask

  function automatic logic [W-1:0] exp_store(input bit req, input bit low,
                                             input logic [W-1:0] c, input logic [W-1:0] prev);
    return (req && !low) ? c : prev;
  endfunction

  // run the remaining NB edges and check the end (R4, R5)
  task automatic run_busy(input logic [W-1:0] c, input bit disturb);
    for (int e = 1; e < NB; e++) begin
      idle($urandom % 3);
      if (disturb && e == 2) tick(1, 1, 1, 0);
      else tick(1, 0, 0, 0);
      check(busy === 1 && store_we === 0, "R4 busy mid-cycle", busy, 1);
    end
    idle($urandom % 3);
    live_code = ~c;
    tick(1, disturb, disturb, 0);
    check(store_we === 1 && busy === 0 && ready_busy === 1, "R5 end edge", {store_we, busy, ready_busy}, 3'b101);
    check(stored_code === c, "R5/R8 stored code", stored_code, c);
    idle(1);
    check(store_we === 0, "R5 strobe width", store_we, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    exp_st = RC;
    idle(3);
    check(ready_busy === 1 && busy === 0 && store_we === 0 && stored_code === RC,
          "R1 reset", {ready_busy, busy, store_we, stored_code}, {3'b100, RC});
    rst_n = 1;
    idle(2);

    // R2 / R4 / R5 basic store
    send_frame(8'h3C);
    idle(2);
    tick(1, 0, 1, 0);
    check(busy === 1 && ready_busy === 0, "R2 start", {busy, ready_busy}, 2'b10);
    idle(20);
    check(busy === 1, "R4 no serial edges holds busy", busy, 1);
    run_busy(8'h3C, 0);
    exp_st = 8'h3C;

    // R3 prog low at sampling edge, then late prog
    send_frame(8'hA1);
    tick(1, 0, 0, 0);
    check(busy === 0, "R3 no request", busy, 0);
    tick(1, 0, 1, 0);
    check(busy === 0 && stored_code === exp_st, "R3 late prog ignored", busy, 0);

    // R6 supply low
    send_frame(8'hC7);
    tick(1, 0, 1, 1);
    check(busy === 0 && ready_busy === 1 && store_we === 0, "R6 supply low", {busy, ready_busy}, 2'b01);
    tick(1, 0, 1, 0);
    check(busy === 0 && stored_code === exp_st, "R6 arming dropped", stored_code, exp_st);

    // R7 disturbance during busy plus frame at the final edge
    send_frame(8'h81);
    tick(1, 0, 1, 0);
    check(busy === 1, "R2 start 2", busy, 1);
    run_busy(8'h81, 1);
    exp_st = 8'h81;
    tick(1, 0, 1, 0);
    check(busy === 0, "R7 not armed after busy", busy, 0);

    // random runs
    for (int k = 0; k < 30; k++) begin
      logic [W-1:0] c;
      bit rq, lo;
      c  = W'($urandom);
      rq = $urandom % 2;
      lo = ($urandom % 4) == 0;
      send_frame(c);
      idle($urandom % 4);
      tick(1, 0, rq, lo);
      if (rq && !lo) begin
        check(busy === 1, "R2 random start", busy, 1);
        run_busy(c, $urandom % 2);
      end else begin
        check(busy === 0 && ready_busy === 1, "R3/R6 random no start", busy, 0);
      end
      exp_st = exp_store(rq, lo, c, exp_st);
      check(stored_code === exp_st, "R8 random stored", stored_code, exp_st);
      idle(2);
    end
    summary();
  end
endmodule